// File: doc/BRIEF.md
# Neighbour Congestion Lookahead and VC Request Suppression

This block sits at one input port of a virtual-channel router and decides, each cycle, which of the port's virtual channels may present a transfer request to switch arbitration. It looks a fixed stride K cycles ahead at every neighbouring router. It adds the credits held locally for a direction to a short departure forecast returned by that neighbour. When the sum is at most K, the direction is flagged as likely to congest.

For a flagged direction, the block suppresses requests from channels whose packet turns, one hop later, into a region reported as busy by a 3-bit traffic metric. Packets bound for quieter regions beyond the same neighbour then go first. A fairness escape applies: when every active channel toward a neighbour would be suppressed, none of them is. The block also holds the forecaster that this port returns to its own upstream neighbour. Given the current wormhole winner, the forecaster predicts how many flits will leave over the next K cycles.

Direction codes are 0 east, 1 south, 2 west, 3 north and 4 local ejection. Arbitration is not part of the block.

Top module: `ncp_congest_mask`

## Requirements
- R1: One clock edge after `win_valid` is sampled high, `dep_pred` equals the smallest of three values: `win_len`, the stride K, and the free-buffer forecast in `fwd_avail` for `win_dir`. A `win_dir` of 4 (local) has no forecast and uses K in its place. The result saturates at 7.
- R2: One clock edge after `win_valid` is sampled low, `dep_pred` is 0.
- R3: For neighbour direction d (0..3), the predicted availability is `credit_in[d]` plus `nbr_pred[d]`, computed without overflow. Direction d counts as congested when that sum is at most K, including the case where it equals K exactly.
- R4: A channel is high-traffic when it targets neighbour d and `metric_in` for the pair (d, next-hop direction) is at least K+1. Field (d,n) occupies bits [(d*4+n)*3 +: 3]. A next-hop direction of 4 always counts as low traffic.
- R5: The block drops a valid channel's request (`xfer_ok` low) only when its current-hop direction is congested and the channel is high-traffic without exemption. Every other valid channel has `xfer_ok` high.
- R6: When every valid channel aimed at neighbour d is high-traffic, none of those channels is suppressed, even if d is congested.
- R7: A channel whose current-hop direction is 4 (local) is never suppressed.
- R8: A channel with `vc_valid` low has `xfer_ok` low.
- R9: While reset is applied and for the cycles after it until a winner is sampled, `dep_pred` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| credit_in | input | 4*CW | Credits held for each neighbour's input buffer, field d at [d*CW +: CW] |
| nbr_pred | input | 12 | 3-bit departure forecast from each neighbour |
| metric_in | input | 48 | 3-bit traffic metric per (neighbour, next-hop) pair |
| vc_valid | input | NVC | Channel has a pending request |
| vc_dir | input | 3*NVC | Current-hop direction per channel |
| vc_ndir | input | 3*NVC | Next-hop direction per channel |
| xfer_ok | output | NVC | Request allowed to proceed |
| win_valid | input | 1 | This port has a wormhole winner |
| win_dir | input | 3 | Output direction of the winner |
| win_len | input | CW | Flits queued in the winner's list |
| fwd_avail | input | 4*AW | Free-buffer forecast per output direction |
| dep_pred | output | 3 | Departure forecast returned upstream |

## Verification
Congestion detection and the all-high exemption are evaluated together for one neighbour in the same cycle. The stress case is a direction that is congested exactly at the threshold while every active channel toward it reports a busy next region. The bench drives those cases and checks that the exemption wins and every request passes. Removing one busy channel then restores suppression of only the remaining busy ones. The registered forecast is updated on the same edge as the combinational masking inputs change. The bench checks it one edge later, independently of the mask result.

// File: rtl/ncp_pkg.sv
package ncp_pkg;
  localparam int unsigned NDIR   = 4;
  localparam int unsigned DIRW   = 3;
  localparam int unsigned PREDW  = 3;
  localparam int unsigned METW   = 3;
  localparam logic [DIRW-1:0] DIR_LOCAL = 3'd4;
  localparam logic [PREDW-1:0] PRED_MAX = 3'd7;
endpackage

// File: rtl/ncp_avail.sv
module ncp_avail
  import ncp_pkg::*;
#(
  parameter int unsigned CW      = 5,
  parameter int unsigned K_STRIDE = 4,
  localparam int unsigned AW     = CW + 1
) (
  input  logic [CW-1:0]    credit,
  input  logic [PREDW-1:0] nbr_pred,
  output logic [AW-1:0]    avail,
  output logic             congested
);
  localparam logic [AW-1:0] KLIM = AW'(K_STRIDE);

  always_comb begin
    avail     = AW'(credit) + AW'(nbr_pred);
    congested = (avail <= KLIM);
  end
endmodule

// File: rtl/ncp_avoid.sv
module ncp_avoid
  import ncp_pkg::*;
#(
  parameter int unsigned NVC      = 4,
  parameter int unsigned DIR_ID   = 0,
  parameter int unsigned K_STRIDE = 4
) (
  input  logic [NVC-1:0]       vc_valid,
  input  logic [NVC*DIRW-1:0]  vc_dir,
  input  logic [NVC*DIRW-1:0]  vc_ndir,
  input  logic [NDIR*METW-1:0] region_metric,
  output logic [NVC-1:0]       mask
);
  localparam logic [METW-1:0] MTHR = METW'(K_STRIDE + 1);

  logic [NVC-1:0] sel;
  logic [NVC-1:0] busy;
  logic           all_busy;

  always_comb begin
    for (int v = 0; v < NVC; v++) begin
      logic [DIRW-1:0] nd;
      nd     = vc_ndir[v*DIRW +: DIRW];
      sel[v] = vc_valid[v] && (vc_dir[v*DIRW +: DIRW] == DIRW'(DIR_ID));
      if (nd < DIRW'(NDIR))
        busy[v] = (region_metric[nd[1:0]*METW +: METW] >= MTHR);
      else
        busy[v] = 1'b0;
    end
    all_busy = (|sel) && ((sel & ~busy) == '0);
    mask     = sel & busy & {NVC{~all_busy}};
  end
endmodule

// File: rtl/ncp_depart_pred.sv
module ncp_depart_pred
  import ncp_pkg::*;
#(
  parameter int unsigned CW       = 5,
  parameter int unsigned K_STRIDE = 4,
  localparam int unsigned AW      = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  input  logic [DIRW-1:0]      win_dir,
  input  logic [CW-1:0]        win_len,
  input  logic [NDIR*AW-1:0]   fwd_avail,
  output logic [PREDW-1:0]     pred_q
);
  localparam logic [AW-1:0] KLIM = AW'(K_STRIDE);

  logic [AW-1:0]    fcast;
  logic [AW-1:0]    m1;
  logic [AW-1:0]    m2;
  logic [PREDW-1:0] pred_d;
  logic             upd_en;

  always_comb begin
    if (win_dir < DIRW'(NDIR)) fcast = fwd_avail[win_dir[1:0]*AW +: AW];
    else                       fcast = KLIM;
    m1 = (fcast < KLIM) ? fcast : KLIM;
    m2 = (AW'(win_len) < m1) ? AW'(win_len) : m1;
    if (!win_valid)                  pred_d = '0;
    else if (m2 > AW'(PRED_MAX))     pred_d = PRED_MAX;
    else                             pred_d = m2[PREDW-1:0];
    upd_en = win_valid || (pred_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pred_q <= '0;
    else if (upd_en) pred_q <= pred_d;
  end
endmodule

// File: rtl/ncp_congest_mask.sv
module ncp_congest_mask
  import ncp_pkg::*;
#(
  parameter int unsigned NVC       = 4,
  parameter int unsigned BUF_DEPTH = 16,
  parameter int unsigned K_STRIDE  = 4,
  localparam int unsigned CW       = $clog2(BUF_DEPTH + 1),
  localparam int unsigned AW       = CW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NDIR*CW-1:0]     credit_in,
  input  logic [NDIR*PREDW-1:0]  nbr_pred,
  input  logic [NDIR*NDIR*METW-1:0] metric_in,
  input  logic [NVC-1:0]         vc_valid,
  input  logic [NVC*DIRW-1:0]    vc_dir,
  input  logic [NVC*DIRW-1:0]    vc_ndir,
  output logic [NVC-1:0]         xfer_ok,
  input  logic                   win_valid,
  input  logic [DIRW-1:0]        win_dir,
  input  logic [CW-1:0]          win_len,
  input  logic [NDIR*AW-1:0]     fwd_avail,
  output logic [PREDW-1:0]       dep_pred
);
  logic [1:0]        rst_sync;
  logic              rst_n_int;
  logic [NDIR-1:0]   cong_vec;
  logic [NDIR*AW-1:0] avail_vec;
  logic [NVC-1:0]    mask_dir [NDIR];
  logic [NVC-1:0]    mask_all;
  logic [NVC-1:0]    cong_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ncp_avail #(.CW(CW), .K_STRIDE(K_STRIDE)) u_avail (
      .credit    (credit_in[d*CW +: CW]),
      .nbr_pred  (nbr_pred[d*PREDW +: PREDW]),
      .avail     (avail_vec[d*AW +: AW]),
      .congested (cong_vec[d])
    );
    ncp_avoid #(.NVC(NVC), .DIR_ID(d), .K_STRIDE(K_STRIDE)) u_avoid (
      .vc_valid      (vc_valid),
      .vc_dir        (vc_dir),
      .vc_ndir       (vc_ndir),
      .region_metric (metric_in[d*NDIR*METW +: NDIR*METW]),
      .mask          (mask_dir[d])
    );
  end

  always_comb begin
    mask_all = '0;
    for (int d = 0; d < NDIR; d++) mask_all = mask_all | mask_dir[d];
    for (int v = 0; v < NVC; v++) begin
      logic [DIRW-1:0] cd;
      cd = vc_dir[v*DIRW +: DIRW];
      cong_sel[v] = (cd < DIRW'(NDIR)) ? cong_vec[cd[1:0]] : 1'b0;
    end
    xfer_ok = vc_valid & ~(cong_sel & mask_all);
  end

  ncp_depart_pred #(.CW(CW), .K_STRIDE(K_STRIDE)) u_pred (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .win_valid (win_valid),
    .win_dir   (win_dir),
    .win_len   (win_len),
    .fwd_avail (fwd_avail),
    .pred_q    (dep_pred)
  );
endmodule

// File: rtl/ncp_congest_mask_chk.sv
module ncp_congest_mask_chk
  import ncp_pkg::*;
#(
  parameter int unsigned NVC      = 4,
  parameter int unsigned K_STRIDE = 4,
  parameter int unsigned CW       = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NVC-1:0]      vc_valid,
  input logic [NVC*DIRW-1:0] vc_dir,
  input logic [NVC-1:0]      xfer_ok,
  input logic [NDIR-1:0]     cong_vec,
  input logic                win_valid,
  input logic [CW-1:0]       win_len,
  input logic [PREDW-1:0]    dep_pred
);
  logic [NDIR-1:0] any_sel;
  logic [NDIR-1:0] any_pass;
  logic [NVC-1:0]  drop_no_cong;
  logic [NVC-1:0]  local_drop;

  always_comb begin
    any_sel = '0; any_pass = '0; drop_no_cong = '0; local_drop = '0;
    for (int v = 0; v < NVC; v++) begin
      logic [DIRW-1:0] cd;
      cd = vc_dir[v*DIRW +: DIRW];
      if (vc_valid[v] && cd < DIRW'(NDIR)) begin
        any_sel[cd[1:0]] = 1'b1;
        if (xfer_ok[v]) any_pass[cd[1:0]] = 1'b1;
        else if (!cong_vec[cd[1:0]]) drop_no_cong[v] = 1'b1;
      end
      if (vc_valid[v] && cd == DIR_LOCAL && !xfer_ok[v]) local_drop[v] = 1'b1;
    end
  end

  AST_PRED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    dep_pred <= PREDW'(K_STRIDE)); // R1
  AST_PRED_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_valid) |-> (CW'(dep_pred) <= $past(win_len))); // R1
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!win_valid) |-> dep_pred == '0); // R2
  AST_DROP_NEEDS_CONG: assert property (@(posedge clk) disable iff (!rst_n)
    drop_no_cong == '0); // R5
  AST_ESCAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_sel & ~any_pass) == '0); // R6
  AST_LOCAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    local_drop == '0); // R7
  AST_IDLE_VC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ok & ~vc_valid) == '0); // R8
endmodule

bind ncp_congest_mask ncp_congest_mask_chk #(.NVC(NVC), .K_STRIDE(K_STRIDE), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .vc_valid  (vc_valid),
  .vc_dir    (vc_dir),
  .xfer_ok   (xfer_ok),
  .cong_vec  (cong_vec),
  .win_valid (win_valid),
  .win_len   (win_len),
  .dep_pred  (dep_pred)
);

// File: tb/tb_ncp_congest_mask.sv
module tb_ncp_congest_mask;
  localparam int NVC = 4;
  localparam int CW  = 5;
  localparam int AW  = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [4*CW-1:0] credit_in;
  logic [11:0]     nbr_pred;
  logic [47:0]     metric_in;
  logic [NVC-1:0]  vc_valid;
  logic [3*NVC-1:0] vc_dir;
  logic [3*NVC-1:0] vc_ndir;
  logic [NVC-1:0]  xfer_ok;
  logic            win_valid;
  logic [2:0]      win_dir;
  logic [CW-1:0]   win_len;
  logic [4*AW-1:0] fwd_avail;
  logic [2:0]      dep_pred;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ncp_congest_mask dut (
    .clk(clk), .rst_n(rst_n), .credit_in(credit_in), .nbr_pred(nbr_pred),
    .metric_in(metric_in), .vc_valid(vc_valid), .vc_dir(vc_dir), .vc_ndir(vc_ndir),
    .xfer_ok(xfer_ok), .win_valid(win_valid), .win_dir(win_dir), .win_len(win_len),
    .fwd_avail(fwd_avail), .dep_pred(dep_pred)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_vc(input int v, input bit val, input int d, input int nd);
    vc_valid[v] = val;
    vc_dir[v*3 +: 3] = 3'(d);
    vc_ndir[v*3 +: 3] = 3'(nd);
  endtask

  task automatic set_met(input int d, input int n, input int m);
    metric_in[(d*4+n)*3 +: 3] = 3'(m);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; win_valid = 1'b1; win_dir = 3'd0; win_len = 5'd3;
    fwd_avail = '1;
    credit_in = '1; nbr_pred = '0; metric_in = '0; vc_valid = '0; vc_dir = '0; vc_ndir = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset pred", dep_pred, 0);
    win_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle pred", dep_pred, 0);
  endtask

  task automatic t_pred;
    fwd_avail = '0;
    fwd_avail[2*AW +: AW] = 6'd9;
    win_valid = 1'b1; win_dir = 3'd2; win_len = 5'd3;
    @(negedge clk);
    chk("R1 len smallest", dep_pred, 3);
    win_len = 5'd10;
    @(negedge clk);
    chk("R1 stride smallest", dep_pred, 4);
    fwd_avail[2*AW +: AW] = 6'd2;
    @(negedge clk);
    chk("R1 forecast smallest", dep_pred, 2);
    win_dir = 3'd4; win_len = 5'd6;
    @(negedge clk);
    chk("R1 local winner", dep_pred, 4);
    win_valid = 1'b0;
    @(negedge clk);
    chk("R2 no winner", dep_pred, 0);
  endtask

  task automatic t_mask;
    credit_in = '1; nbr_pred = '0; metric_in = '0; vc_valid = '0;
    set_vc(0, 1, 0, 1); set_met(0, 1, 6);
    set_vc(1, 1, 0, 2); set_met(0, 2, 1);
    credit_in[0 +: CW] = 5'd2; nbr_pred[0 +: 3] = 3'd1;
    settle();
    chk("R5 congested busy dropped", xfer_ok, 4'b0010);
    credit_in[0 +: CW] = 5'd3;
    settle();
    chk("R3 avail equal K congested", xfer_ok, 4'b0010);
    credit_in[0 +: CW] = 5'd4;
    settle();
    chk("R3 avail K+1 not congested", xfer_ok, 4'b0011);
    credit_in[0 +: CW] = 5'd1; nbr_pred[0 +: 3] = 3'd4;
    settle();
    chk("R3 pred adds to credit", xfer_ok, 4'b0011);
    nbr_pred[0 +: 3] = 3'd0; set_met(0, 1, 5);
    settle();
    chk("R4 metric K+1 busy", xfer_ok, 4'b0010);
    set_met(0, 1, 4);
    settle();
    chk("R4 metric K low", xfer_ok, 4'b0011);
    set_met(0, 1, 7); set_vc(0, 1, 0, 4);
    settle();
    chk("R4 local next hop low", xfer_ok, 4'b0011);
  endtask

  task automatic t_escape;
    metric_in = '0; vc_valid = '0; credit_in = '1; nbr_pred = '0;
    credit_in[0 +: CW] = 5'd3; nbr_pred[0 +: 3] = 3'd1;
    set_vc(0, 1, 0, 1); set_met(0, 1, 7);
    set_vc(1, 1, 0, 2); set_met(0, 2, 6);
    settle();
    chk("R6 all busy exempt", xfer_ok, 4'b0011);
    set_vc(2, 1, 0, 3); set_met(0, 3, 0);
    settle();
    chk("R6 one low restores mask", xfer_ok, 4'b0100);
    set_vc(3, 1, 1, 2); set_met(1, 2, 7);
    credit_in[1*CW +: CW] = 5'd0;
    settle();
    chk("R6 lone busy on other dir", xfer_ok, 4'b1100);
  endtask

  task automatic t_local_idle;
    metric_in = '1; credit_in = '0; nbr_pred = '0; vc_valid = '0;
    set_vc(0, 1, 4, 1);
    set_vc(1, 1, 2, 1);
    set_vc(2, 1, 2, 3);
    set_vc(3, 0, 2, 0);
    settle();
    chk("R7 local dir passes", xfer_ok[0], 1);
    chk("R8 invalid low", xfer_ok[3], 0);
    chk("R6 busy pair exempt", xfer_ok[2:1], 3);
    vc_valid = '0;
    settle();
    chk("R8 all idle", xfer_ok, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pred();
        t_mask();
        t_escape();
        t_local_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule